// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits next to a small processor core and decides when ordinary instruction flow must give way to exception handling. It watches three sources: the release of the active-low reset pin, a level-sensitive interrupt request that carries a vector number, and a trap strobe that carries a trap number. Reset has the highest priority, then the interrupt, then the trap. The core reports its instruction boundaries, whether the instruction that just ended changed the condition-code register, and its current program counter, condition codes and stack pointer.

When an exception wins, the block takes over a 16-bit synchronous memory bus. For interrupts and traps it saves the program counter and condition codes on a downward-growing stack. Every exception then reads a 32-bit start address from a table indexed by vector number, and the block hands the new PC, CCR and SP back to the core in one cycle. If another exception is already due when a sequence ends, the next entry starts at once and saves the state that the previous entry produced.

Top module: `exc_entry_seq`

## Requirements
- R1: The priority order is reset, then interrupt, then trap. When an interrupt and a trap are both due at the same boundary, the interrupt entry runs first and the trap entry follows directly after it.
- R2: While `rst_n` is low, `exc_busy` is 1 and the bus is idle. Once the synchronised `rst_n` has gone high, a reset entry runs. It makes no bus writes, reads table words 0 and 2, loads that address into the PC, loads CCR = 0x80 and leaves the SP unloaded.
- R3: An interrupt can be accepted only at an instruction boundary (`insn_end` while idle) or in the last cycle of an exception sequence. It is never accepted in the middle of a sequence, and a request without a boundary has no effect.
- R4: An interrupt is not accepted at a boundary where `ccr_wr` is 1. It is also not accepted at the end of a reset entry, nor at the first instruction boundary after that entry.
- R5: A trap is accepted at any boundary where `trap_req` is 1, whatever the value of CCR bit 7. A `trap_req` that arrives while `exc_busy` is 1 is ignored. The trap entry leaves the CCR value unchanged.
- R6: Interrupt and trap entries make four 16-bit writes, in this order: PC[31:16] to SP-4, PC[15:0] to SP-2, 0x0000 to SP-8, and {0x00, CCR} to SP-6. The entry then returns SP-8 on `sp_new`.
- R7: The table entry for vector v is at byte address 4*v. The high half is read first and the half at 4*v+2 is read next. Read data appears on `mem_rdata` in the cycle after the request. `pc_load` pulses in the cycle after the second read, with `pc_new` = {high, low}.
- R8: CCR bit 7 is the interrupt mask. An interrupt is held off while that bit is 1, and an interrupt entry returns a CCR with bit 7 set.
- R9: `irq_ack` is a one-cycle pulse, given in the first cycle of an interrupt entry (the same cycle as the first stack write). `irq_ack_vec` carries the accepted vector number in that cycle.
- R10: When a new entry starts at the end of a sequence, it saves the PC, CCR and SP produced by the sequence that just finished, and it starts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin; resets the block and, on release, starts the reset entry |
| irq_req | input | 1 | Level interrupt request |
| irq_vec | input | VEC_W | Vector number of the interrupt request |
| trap_req | input | 1 | Trap instruction finished (sampled with `insn_end`) |
| trap_num | input | VEC_W | Vector number of the trap |
| insn_end | input | 1 | The core finishes an instruction in this cycle |
| ccr_wr | input | 1 | The instruction that is ending changed the CCR |
| cpu_pc | input | 32 | Current program counter of the core |
| cpu_ccr | input | 8 | Current condition codes; bit 7 is the interrupt mask |
| cpu_sp | input | 32 | Current stack pointer |
| exc_busy | output | 1 | An exception entry is running or reset is not yet handled; the core stalls |
| irq_ack | output | 1 | Pulse on acceptance of an interrupt |
| irq_ack_vec | output | VEC_W | Vector number being acknowledged |
| pc_load | output | 1 | Load `pc_new` into the PC |
| pc_new | output | 32 | New program counter |
| ccr_load | output | 1 | Load `ccr_new` into the CCR |
| ccr_new | output | 8 | New condition codes |
| sp_load | output | 1 | Load `sp_new` into the SP |
| sp_new | output | 32 | New stack pointer |
| mem_req | output | 1 | Bus cycle request |
| mem_we | output | 1 | Bus write when 1, read when 0 |
| mem_addr | output | 32 | Byte address of the bus cycle |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the cycle after a read request |

## Verification
The bench holds an interrupt request high across the first boundary after reset and across a boundary where `ccr_wr` is 1. A design that ignored either blocking rule would start an extra entry, and the scoreboard would see stack writes it did not expect. It raises a trap and an interrupt together, and it also raises an interrupt part-way through a trap entry. A wrong priority, or an interrupt taken in the middle of a sequence, would put the stack writes in the wrong order. The chained entries also show whether the second push uses the freshly loaded PC, CCR and SP, since stale core values would produce wrong data and wrong addresses. A second reset in mid-run must make no writes and must leave the SP unloaded. A trap that arrives while the CCR mask bit is set must still be taken.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int WORD_W   = 32;
  localparam int HALF_W   = 16;
  localparam int CCR_W    = 8;
  localparam int MASK_BIT = 7;
  localparam int FRAME_B  = 8;

  typedef enum logic [1:0] {
    K_RST  = 2'd0,
    K_IRQ  = 2'd1,
    K_TRAP = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PC_H, S_PC_L, S_CC_H, S_CC_L, S_VEC_H, S_VEC_L, S_VEC_W
  } st_e;

  // byte address of a table entry
  function automatic logic [WORD_W-1:0] table_addr(input logic [WORD_W-1:0] num);
    return num << 2;
  endfunction

  // condition codes handed back at the end of an entry
  function automatic logic [CCR_W-1:0] ccr_after(input kind_e k, input logic [CCR_W-1:0] c);
    case (k)
      K_RST:   return CCR_W'(1) << MASK_BIT;
      K_IRQ:   return c | (CCR_W'(1) << MASK_BIT);
      default: return c;
    endcase
  endfunction

  // stack pointer after saving PC and CCR
  function automatic logic [WORD_W-1:0] sp_after(input logic [WORD_W-1:0] sp);
    return sp - WORD_W'(FRAME_B);
  endfunction

endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic synced
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= 1'b1;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= {q[STAGES-2:0], 1'b1};
    end
  endgenerate

  assign synced = q[STAGES-1];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             rst_go,
  input  logic             bnd,
  input  logic             irq_req,
  input  logic             irq_mask,
  input  logic             irq_block,
  input  logic             trap_go,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [VEC_W-1:0] trap_vec,
  output logic             take,
  output kind_e            kind,
  output logic [VEC_W-1:0] vec
);
  logic irq_go;
  assign irq_go = bnd & irq_req & ~irq_mask & ~irq_block;

  always_comb begin
    take = 1'b0;
    kind = K_RST;
    vec  = '0;
    if (rst_go) begin
      take = 1'b1;
    end else if (irq_go) begin
      take = 1'b1;
      kind = K_IRQ;
      vec  = irq_vec;
    end else if (bnd && trap_go) begin
      take = 1'b1;
      kind = K_TRAP;
      vec  = trap_vec;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic              trap_req,
  input  logic [VEC_W-1:0]  trap_num,
  input  logic              insn_end,
  input  logic              ccr_wr,
  input  logic [31:0]       cpu_pc,
  input  logic [7:0]        cpu_ccr,
  input  logic [31:0]       cpu_sp,
  output logic              exc_busy,
  output logic              irq_ack,
  output logic [VEC_W-1:0]  irq_ack_vec,
  output logic              pc_load,
  output logic [31:0]       pc_new,
  output logic              ccr_load,
  output logic [7:0]        ccr_new,
  output logic              sp_load,
  output logic [31:0]       sp_new,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);
  st_e                st_q;
  kind_e              kind_q;
  logic [VEC_W-1:0]   vec_q, tnum_q;
  logic [WORD_W-1:0]  pc_q, sp_q;
  logic [CCR_W-1:0]   ccr_q;
  logic [HALF_W-1:0]  hi_q;
  logic               rst_done_q, blk_rst_q, trap_pend_q;

  // named events
  logic rst_sync, idle, seq_end, idle_bnd, bnd, rst_go, trap_now, trap_go;
  logic irq_block, irq_mask, take;
  kind_e arb_kind;
  logic [VEC_W-1:0]  arb_vec, trap_sel;
  logic [WORD_W-1:0] pc_res, sp_res, pc_src, sp_src, vaddr;
  logic [CCR_W-1:0]  ccr_res, ccr_src;

  exc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .synced(rst_sync)
  );

  assign idle      = (st_q == S_IDLE);
  assign seq_end   = (st_q == S_VEC_W);
  assign idle_bnd  = idle & rst_done_q & insn_end;
  assign bnd       = idle_bnd | seq_end;
  assign rst_go    = idle & rst_sync & ~rst_done_q;
  assign trap_now  = idle_bnd & trap_req;
  assign trap_go   = trap_pend_q | trap_now;
  assign trap_sel  = trap_pend_q ? tnum_q : trap_num;
  assign irq_block = blk_rst_q | (idle_bnd & ccr_wr) | (seq_end & (kind_q == K_RST));

  assign pc_res  = {hi_q, mem_rdata};
  assign ccr_res = ccr_after(kind_q, ccr_q);
  assign sp_res  = sp_after(sp_q);

  // a chained entry saves what the finishing entry produced
  assign pc_src   = seq_end ? pc_res  : cpu_pc;
  assign ccr_src  = seq_end ? ccr_res : cpu_ccr;
  assign sp_src   = seq_end ? sp_res  : cpu_sp;
  assign irq_mask = ccr_src[MASK_BIT];

  exc_arbiter #(.VEC_W(VEC_W)) u_arb (
    .rst_go(rst_go), .bnd(bnd), .irq_req(irq_req), .irq_mask(irq_mask),
    .irq_block(irq_block), .trap_go(trap_go), .irq_vec(irq_vec),
    .trap_vec(trap_sel), .take(take), .kind(arb_kind), .vec(arb_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      kind_q      <= K_RST;
      vec_q       <= '0;
      tnum_q      <= '0;
      pc_q        <= '0;
      sp_q        <= '0;
      ccr_q       <= '0;
      hi_q        <= '0;
      rst_done_q  <= 1'b0;
      blk_rst_q   <= 1'b0;
      trap_pend_q <= 1'b0;
    end else begin
      if (take) begin
        st_q   <= (arb_kind == K_RST) ? S_VEC_H : S_PC_H;
        kind_q <= arb_kind;
        vec_q  <= arb_vec;
        pc_q   <= pc_src;
        ccr_q  <= ccr_src;
        sp_q   <= sp_src;
      end else begin
        case (st_q)
          S_PC_H:  st_q <= S_PC_L;
          S_PC_L:  st_q <= S_CC_H;
          S_CC_H:  st_q <= S_CC_L;
          S_CC_L:  st_q <= S_VEC_H;
          S_VEC_H: st_q <= S_VEC_L;
          S_VEC_L: st_q <= S_VEC_W;
          default: st_q <= S_IDLE;
        endcase
      end

      if (st_q == S_VEC_L) hi_q <= mem_rdata;

      if (take && arb_kind == K_TRAP) trap_pend_q <= 1'b0;
      else if (trap_now) begin
        trap_pend_q <= 1'b1;
        tnum_q      <= trap_num;
      end

      if (seq_end && kind_q == K_RST) begin
        rst_done_q <= 1'b1;
        blk_rst_q  <= 1'b1;
      end else if (idle_bnd) begin
        blk_rst_q  <= 1'b0;
      end
    end
  end

  assign vaddr = table_addr(WORD_W'(vec_q));

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st_q)
      S_PC_H:  begin mem_we = 1'b1; mem_addr = sp_q - 32'd4; mem_wdata = pc_q[31:16]; end
      S_PC_L:  begin mem_we = 1'b1; mem_addr = sp_q - 32'd2; mem_wdata = pc_q[15:0]; end
      S_CC_H:  begin mem_we = 1'b1; mem_addr = sp_q - 32'd8; end
      S_CC_L:  begin mem_we = 1'b1; mem_addr = sp_q - 32'd6; mem_wdata = {8'h00, ccr_q}; end
      S_VEC_H: mem_addr = vaddr;
      S_VEC_L: mem_addr = vaddr + 32'd2;
      default: mem_req = 1'b0;
    endcase
  end

  assign exc_busy    = ~idle | ~rst_done_q;
  assign irq_ack     = (st_q == S_PC_H) & (kind_q == K_IRQ);
  assign irq_ack_vec = vec_q;
  assign pc_load     = seq_end;
  assign pc_new      = pc_res;
  assign ccr_load    = seq_end;
  assign ccr_new     = ccr_res;
  assign sp_load     = seq_end & (kind_q != K_RST);
  assign sp_new      = sp_res;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic clk,
  input logic rst_n,
  input logic exc_busy,
  input logic irq_ack,
  input logic insn_end,
  input logic ccr_wr,
  input logic mem_req,
  input logic mem_we,
  input logic pc_load,
  input logic rst_done,
  input logic bnd,
  input logic irq_mask
);
  a_r2_no_write_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_done |-> !mem_we);

  a_r3_ack_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(bnd));

  a_r4_ccr_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_busy && insn_end && ccr_wr) |=> !irq_ack);

  a_r6_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> exc_busy);

  a_r7_load_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(mem_req && !mem_we));

  a_r8_unmasked_accept: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(!irq_mask));

  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);
endmodule

bind exc_entry_seq exc_entry_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exc_busy(exc_busy), .irq_ack(irq_ack),
  .insn_end(insn_end), .ccr_wr(ccr_wr), .mem_req(mem_req), .mem_we(mem_we),
  .pc_load(pc_load), .rst_done(rst_done_q), .bnd(bnd), .irq_mask(irq_mask)
);

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;
  localparam int VW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic irq_req = 1'b0, trap_req = 1'b0, insn_end = 1'b0, ccr_wr = 1'b0;
  logic [VW-1:0] irq_vec = '0, trap_num = '0, irq_ack_vec;
  logic [31:0] cpu_pc = 32'h0000_1000, cpu_sp = 32'h0000_F000;
  logic [7:0]  cpu_ccr = 8'h00;
  logic exc_busy, irq_ack, pc_load, ccr_load, sp_load, mem_req, mem_we;
  logic [31:0] pc_new, sp_new, mem_addr;
  logic [7:0]  ccr_new;
  logic [15:0] mem_wdata, mem_rdata = 16'h0;

  int checks = 0, errors = 0;

  exc_entry_seq #(.VEC_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
    .trap_req(trap_req), .trap_num(trap_num), .insn_end(insn_end), .ccr_wr(ccr_wr),
    .cpu_pc(cpu_pc), .cpu_ccr(cpu_ccr), .cpu_sp(cpu_sp), .exc_busy(exc_busy),
    .irq_ack(irq_ack), .irq_ack_vec(irq_ack_vec), .pc_load(pc_load), .pc_new(pc_new),
    .ccr_load(ccr_load), .ccr_new(ccr_new), .sp_load(sp_load), .sp_new(sp_new),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // memory model: table contents are a function of the address
  function automatic logic [15:0] mw(input logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction
  function automatic logic [31:0] vp(input int v);
    return {mw(32'(v) * 4), mw(32'(v) * 4 + 2)};
  endfunction
  always @(posedge clk) if (mem_req && !mem_we) mem_rdata <= mw(mem_addr);

  // scoreboard: 0 ack, 1 write, 2 read, 3 load
  typedef struct packed {
    logic [1:0]  typ;
    logic [31:0] a;
    logic [31:0] d;
    logic [8:0]  x;
  } item_t;
  item_t q[$];
  string tq[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] t, input logic [31:0] a, input logic [31:0] d,
                      input logic [8:0] x, input string tag);
    q.push_back('{typ: t, a: a, d: d, x: x});
    tq.push_back(tag);
  endtask

  task automatic mon(input item_t got);
    item_t e;
    string tag;
    if (q.size() == 0) begin
      chk(1'b0, "R3 unexpected event", {got.typ, got.a, got.d[29:0]}, 64'h0);
      return;
    end
    e = q.pop_front();
    tag = tq.pop_front();
    chk(got == e, tag, {got.typ, got.a, got.d[29:0]}, {e.typ, e.a, e.d[29:0]});
    if (got != e) $display("  detail %s: x=%0h/%0h d=%0h/%0h", tag, got.x, e.x, got.d, e.d);
  endtask

  always @(negedge clk) begin
    if (irq_ack) mon('{typ: 2'd0, a: 32'(irq_ack_vec), d: 32'h0, x: 9'h0});
    if (mem_req) mon('{typ: mem_we ? 2'd1 : 2'd2, a: mem_addr,
                       d: mem_we ? {16'h0, mem_wdata} : 32'h0, x: 9'h0});
    if (pc_load) mon('{typ: 2'd3, a: pc_new, d: sp_load ? sp_new : 32'h0,
                       x: {sp_load, ccr_load ? ccr_new : 8'h00}});
  end

  // expected entry: kind 0 reset, 1 interrupt, 2 trap
  task automatic exp_seq(input int kind, input int v, input logic [31:0] pc,
                         input logic [7:0] ccr, input logic [31:0] sp,
                         output logic [31:0] npc, output logic [7:0] nccr,
                         output logic [31:0] nsp);
    string lt;
    lt = (kind == 0) ? "R2 reset load" : (kind == 1) ? "R8 irq load" : "R5 trap load";
    if (kind == 1) push(2'd0, 32'(v), 32'h0, 9'h0, "R9 ack");
    if (kind != 0) begin
      push(2'd1, sp - 4, {16'h0, pc[31:16]}, 9'h0, "R6 push pc hi");
      push(2'd1, sp - 2, {16'h0, pc[15:0]},  9'h0, "R6 push pc lo");
      push(2'd1, sp - 8, 32'h0,              9'h0, "R6 push ccr hi");
      push(2'd1, sp - 6, {24'h0, ccr},       9'h0, "R6 push ccr lo");
    end
    push(2'd2, 32'(v) * 4,     32'h0, 9'h0, "R7 table hi");
    push(2'd2, 32'(v) * 4 + 2, 32'h0, 9'h0, "R7 table lo");
    npc  = vp(v);
    nccr = (kind == 0) ? 8'h80 : (kind == 1) ? (ccr | 8'h80) : ccr;
    nsp  = (kind == 0) ? sp : sp - 8;
    push(2'd3, npc, (kind == 0) ? 32'h0 : nsp, {kind != 0, nccr}, lt);
  endtask

  // core model: applies the loads seen in this cycle
  task automatic tick();
    @(negedge clk);
    if (pc_load)  cpu_pc  = pc_new;
    if (ccr_load) cpu_ccr = ccr_new;
    if (sp_load)  cpu_sp  = sp_new;
  endtask

  task automatic insn(input logic cw, input logic tr, input logic [VW-1:0] tn);
    insn_end = 1'b1; ccr_wr = cw; trap_req = tr; trap_num = tn;
    tick();
    insn_end = 1'b0; ccr_wr = 1'b0; trap_req = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (exc_busy && n < 200) begin tick(); n++; end
    chk(!exc_busy, tag, 64'(exc_busy), 64'h0);
  endtask

  initial begin
    logic [31:0] p1, s1, p2, s2;
    logic [7:0]  c1, c2;

    // R2: held in reset
    repeat (3) tick();
    chk(exc_busy == 1'b1, "R2 busy in reset", 64'(exc_busy), 64'h1);
    chk(mem_req == 1'b0, "R2 bus idle in reset", 64'(mem_req), 64'h0);
    chk(pc_load == 1'b0 && irq_ack == 1'b0, "R2 no load in reset", 64'(pc_load), 64'h0);
    exp_seq(0, 0, cpu_pc, cpu_ccr, cpu_sp, p1, c1, s1);
    irq_req = 1'b1; irq_vec = 8'd5;
    rst_n = 1'b1;
    wait_idle("R2 reset entry ends");
    cpu_ccr = 8'h00;

    // R4: first boundary after reset ignores the interrupt
    insn(1'b0, 1'b0, '0);
    repeat (3) tick();
    chk(!exc_busy, "R4 blocked after reset", 64'(exc_busy), 64'h0);

    // R8, R9, R6, R7: interrupt entry
    exp_seq(1, 5, cpu_pc, cpu_ccr, cpu_sp, p1, c1, s1);
    insn(1'b0, 1'b0, '0);
    wait_idle("R8 irq entry ends");
    // R8: mask now set, request still high
    insn(1'b0, 1'b0, '0);
    repeat (3) tick();
    chk(!exc_busy, "R8 masked request ignored", 64'(exc_busy), 64'h0);
    irq_req = 1'b0;

    // R5: trap taken with mask set; trap during busy ignored
    exp_seq(2, 9, cpu_pc, cpu_ccr, cpu_sp, p1, c1, s1);
    insn(1'b0, 1'b1, 8'd9);
    tick(); tick();
    insn(1'b0, 1'b1, 8'd4);
    wait_idle("R5 trap entry ends");
    repeat (10) tick();
    chk(q.size() == 0, "R5 busy trap ignored", 64'(q.size()), 64'h0);

    // R4: ccr-writing instruction boundary
    cpu_ccr = 8'h00;
    irq_req = 1'b1; irq_vec = 8'd3;
    insn(1'b1, 1'b0, '0);
    repeat (3) tick();
    chk(!exc_busy, "R4 ccr write blocks", 64'(exc_busy), 64'h0);
    exp_seq(1, 3, cpu_pc, cpu_ccr, cpu_sp, p1, c1, s1);
    insn(1'b0, 1'b0, '0);
    wait_idle("R4 next boundary taken");
    irq_req = 1'b0;

    // R1, R10: interrupt and trap together, trap chained
    cpu_ccr = 8'h00;
    irq_req = 1'b1; irq_vec = 8'd6;
    exp_seq(1, 6, cpu_pc, cpu_ccr, cpu_sp, p1, c1, s1);
    exp_seq(2, 11, p1, c1, s1, p2, c2, s2);
    insn(1'b0, 1'b1, 8'd11);
    wait_idle("R1 chained pair ends");
    irq_req = 1'b0;
    chk(cpu_sp == s2, "R10 final sp", 64'(cpu_sp), 64'(s2));

    // R3: request without a boundary does nothing
    cpu_ccr = 8'h00;
    irq_req = 1'b1; irq_vec = 8'd4;
    repeat (4) tick();
    chk(!exc_busy, "R3 no boundary no entry", 64'(exc_busy), 64'h0);
    exp_seq(1, 4, cpu_pc, cpu_ccr, cpu_sp, p1, c1, s1);
    insn(1'b0, 1'b0, '0);
    wait_idle("R3 boundary entry ends");
    irq_req = 1'b0;

    // R3, R10: interrupt raised mid-trap, taken at the trap's end
    cpu_ccr = 8'h00;
    exp_seq(2, 2, cpu_pc, cpu_ccr, cpu_sp, p1, c1, s1);
    exp_seq(1, 7, p1, c1, s1, p2, c2, s2);
    insn(1'b0, 1'b1, 8'd2);
    tick(); tick();
    irq_req = 1'b1; irq_vec = 8'd7;
    wait_idle("R10 trap then irq ends");
    irq_req = 1'b0;

    // R2: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    tick(); tick();
    chk(exc_busy == 1'b1 && mem_req == 1'b0, "R2 second reset held", 64'(exc_busy), 64'h1);
    exp_seq(0, 0, cpu_pc, cpu_ccr, cpu_sp, p1, c1, s1);
    s2 = cpu_sp;
    rst_n = 1'b1;
    wait_idle("R2 second reset ends");
    chk(cpu_sp == s2, "R2 sp untouched", 64'(cpu_sp), 64'(s2));

    repeat (5) tick();
    chk(q.size() == 0, "R1 scoreboard drained", 64'(q.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule